// File: doc/BRIEF.md
# Dual-Channel Task-File Register Window with Shadow Select

This block gives a host two ATA-style task-file register sets, one per channel, behind a single pair of 32-bit register words. A hidden one-bit select, the shadow select, decides which channel a shared-window access reaches. The host loads the shadow select by writing the device/head byte. The register bus is a simple single-cycle bus: valid, write, byte address, four byte enables, write data and combinational read data.

A second address range gives each channel its own fixed pair of words. Accesses in that range reach one channel only and ignore the shadow select. Each channel drives its stored task-file bytes and its data register to a downstream engine. Each channel also emits a one-cycle pulse when its command byte is written. The engine supplies the read-only error and status bytes.

Top module: `tf_window_bank`

## Requirements
- R1: After reset every stored register of both channels is zero, the shadow select is 0 (channel 0), `bus_rdata` is zero while no read is in progress, and no command pulse is active.
- R2: Shared word 0 is byte address 0x00. Lane 0 (bits 7:0) is the data byte. Lane 1 (bits 15:8) is features on write and error on read. Lane 2 (bits 23:16) is sector count. Lane 3 (bits 31:24) is start sector. In `eng_tf`, channel c occupies bits c*56+55 down to c*56. Within that field the byte order, from the low end, is features, sector count, start sector, cylinder low, cylinder high, device/head, command.
- R3: Shared word 1 is byte address 0x04. Lane 0 is cylinder low, lane 1 is cylinder high, lane 2 is device/head, and lane 3 is command on write and status on read.
- R4: With the shadow select at 0, shared-window reads and writes reach channel 0. With the shadow select at 1, they reach channel 1.
- R5: A write to shared word 1 with byte enable 2 set loads the shadow select from write-data bit 20, which is bit 4 of the device/head byte. That same bit, not the old shadow value, picks the channel for every lane of the access.
- R6: Bit 4 of every stored device/head register is always 0, whichever path wrote it.
- R7: Channel c's word 0 is at DIRECT_BASE + c*CH_STRIDE and its word 1 is 4 bytes above that. Alias accesses reach channel c regardless of the shadow select and never change it.
- R8: The data register of word 0 is 32 bits wide. Byte enables 1111 access all 32 bits. Byte enables with bits 1:0 set but not all four set access data bits 15:0, and lanes 2 and 3 act as normal fields. Otherwise lane 0 alone touches data bits 7:0.
- R9: Features and command are write-only and never read back. Reads of lane 1 in byte mode return the channel's `eng_error` byte, and reads of lane 3 of word 1 return the channel's `eng_status` byte.
- R10: A lane whose byte enable is clear keeps its register value. A write with byte enable 2 clear leaves the shadow select unchanged.
- R11: A write of the command lane raises the target channel's bit of `eng_cmd_pulse` for exactly the one cycle after the write. At most one bit is ever high.
- R12: Any address that is not 4-byte aligned or falls outside the shared and alias words reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| eng_error | input | 16 | Error byte, 8 bits per channel |
| eng_status | input | 16 | Status byte, 8 bits per channel |
| eng_tf | output | 112 | Stored task-file bytes, 56 bits per channel |
| eng_data | output | 64 | Data register, 32 bits per channel |
| eng_cmd_pulse | output | 2 | Command-written pulse per channel |
| sel_shadow | output | 1 | Current shadow select |

## Verification
The bench builds the block with ADDR_W=8, DIRECT_BASE=0x80 and CH_STRIDE=0x40. This puts channel 1's alias at 0xC0 and 0xC4 and keeps the whole address space at 64 word slots. With so few slots, the bench can sweep every aligned address outside the mapped words and confirm it reads as zero. It also writes through each alias while the shadow select points at the other channel, which separates the steered path from the fixed one. The device/head writes use values whose bit 4 flips against the current shadow. This shows that the incoming bit, not the stored one, picks the target.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    localparam int NUM_CH = 2;
    localparam logic [7:0] DH_SEL_MASK = 8'h10;

    typedef struct packed {
        logic [31:0] data;
        logic [7:0]  feat;
        logic [7:0]  seccnt;
        logic [7:0]  secnum;
        logic [7:0]  cyllo;
        logic [7:0]  cylhi;
        logic [7:0]  devhead;
        logic [7:0]  cmd;
    } tf_regs_t;

    typedef struct packed {
        logic hit;
        logic shared;
        logic ch;
        logic word;
        logic dh_wr;
    } tf_dec_t;

endpackage

// File: rtl/tfb_decode.sv
module tfb_decode
    import tfb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DIRECT_BASE = 'h80,
    parameter int CH_STRIDE   = 'h40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              be_dh,
    input  logic              dh_bit,
    input  logic              shadow,
    output tf_dec_t           dec
);

    logic [NUM_CH-1:0] alias_hit;
    logic              aligned;
    logic              shared_hit;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_alias
            localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DIRECT_BASE + c * CH_STRIDE);
            assign alias_hit[c] = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
        end
    endgenerate

    assign aligned    = (addr[1:0] == 2'b00);
    assign shared_hit = (addr[ADDR_W-1:3] == '0);

    always_comb begin
        dec = '0;
        if (aligned && shared_hit) begin
            dec.hit    = 1'b1;
            dec.shared = 1'b1;
            dec.word   = addr[2];
            dec.dh_wr  = addr[2] && write && be_dh;
            dec.ch     = dec.dh_wr ? dh_bit : shadow;
        end else if (aligned && (alias_hit != '0)) begin
            dec.hit  = 1'b1;
            dec.word = addr[2];
            dec.ch   = alias_hit[1];
        end
    end

endmodule

// File: rtl/tfb_channel.sv
module tfb_channel
    import tfb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        word,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output tf_regs_t    regs,
    output logic        cmd_pulse
);

    typedef struct packed {
        tf_regs_t r;
        logic     pulse;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_en) begin
            if (!word) begin
                if (be == 4'b1111) begin
                    st_d.r.data = wdata;
                end else begin
                    if (be[1:0] == 2'b11) begin
                        st_d.r.data[15:0] = wdata[15:0];
                    end else begin
                        if (be[0]) st_d.r.data[7:0] = wdata[7:0];
                        if (be[1]) st_d.r.feat      = wdata[15:8];
                    end
                    if (be[2]) st_d.r.seccnt = wdata[23:16];
                    if (be[3]) st_d.r.secnum = wdata[31:24];
                end
            end else begin
                if (be[0]) st_d.r.cyllo   = wdata[7:0];
                if (be[1]) st_d.r.cylhi   = wdata[15:8];
                if (be[2]) st_d.r.devhead = wdata[23:16] & ~DH_SEL_MASK;
                if (be[3]) begin
                    st_d.r.cmd = wdata[31:24];
                    st_d.pulse = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs      = st_q.r;
    assign cmd_pulse = st_q.pulse;

    AST_DH_BIT4_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.r.devhead[4] == 1'b0); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.r)); // R10

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word && be[3]) |=> cmd_pulse); // R11

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && !$past(wr_en && word && be[3])) |-> 1'b0); // R11

endmodule

// File: rtl/tf_window_bank.sv
module tf_window_bank
    import tfb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DIRECT_BASE = 'h80,
    parameter int CH_STRIDE   = 'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_CH*8-1:0]  eng_error,
    input  logic [NUM_CH*8-1:0]  eng_status,
    output logic [NUM_CH*56-1:0] eng_tf,
    output logic [NUM_CH*32-1:0] eng_data,
    output logic [NUM_CH-1:0]    eng_cmd_pulse,
    output logic                 sel_shadow
);

    typedef struct packed {
        logic shadow;
    } top_state_t;

    top_state_t st_d, st_q;
    tf_dec_t    dec;
    tf_regs_t   regs_a [NUM_CH];
    logic [7:0] err_a  [NUM_CH];
    logic [7:0] sts_a  [NUM_CH];
    logic       bus_wr;

    assign bus_wr = bus_valid && bus_write;

    tfb_decode #(
        .ADDR_W      (ADDR_W),
        .DIRECT_BASE (DIRECT_BASE),
        .CH_STRIDE   (CH_STRIDE)
    ) u_decode (
        .addr   (bus_addr),
        .write  (bus_wr),
        .be_dh  (bus_be[2]),
        .dh_bit (bus_wdata[20]),
        .shadow (st_q.shadow),
        .dec    (dec)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            tfb_channel u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (bus_wr && dec.hit && (dec.ch == 1'(c))),
                .word      (dec.word),
                .be        (bus_be),
                .wdata     (bus_wdata),
                .regs      (regs_a[c]),
                .cmd_pulse (eng_cmd_pulse[c])
            );
            assign err_a[c] = eng_error[c*8 +: 8];
            assign sts_a[c] = eng_status[c*8 +: 8];
            assign eng_data[c*32 +: 32] = regs_a[c].data;
            assign eng_tf[c*56 +: 56]   = {regs_a[c].cmd, regs_a[c].devhead,
                                           regs_a[c].cylhi, regs_a[c].cyllo,
                                           regs_a[c].secnum, regs_a[c].seccnt,
                                           regs_a[c].feat};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (dec.dh_wr) st_d.shadow = bus_wdata[20];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write && dec.hit) begin
            if (!dec.word) begin
                if (bus_be == 4'b1111) begin
                    bus_rdata = regs_a[dec.ch].data;
                end else begin
                    bus_rdata = {regs_a[dec.ch].secnum, regs_a[dec.ch].seccnt,
                                 (bus_be[1:0] == 2'b11) ? regs_a[dec.ch].data[15:8]
                                                        : err_a[dec.ch],
                                 regs_a[dec.ch].data[7:0]};
                end
            end else begin
                bus_rdata = {sts_a[dec.ch], regs_a[dec.ch].devhead,
                             regs_a[dec.ch].cylhi, regs_a[dec.ch].cyllo};
            end
        end
    end

    assign sel_shadow = st_q.shadow;

    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(4) && bus_be[2])
        |=> sel_shadow == $past(bus_wdata[20])); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_be[2]) |=> $stable(sel_shadow)); // R10

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_cmd_pulse)); // R11

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> bus_rdata == '0); // R1

endmodule

// File: tb/tf_window_bank_test.sv
module tf_window_bank_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [3:0]   bus_be = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  eng_error = {8'h00, 8'h5A};
    logic [15:0]  eng_status = {8'h41, 8'h50};
    logic [111:0] eng_tf;
    logic [63:0]  eng_data;
    logic [1:0]   eng_cmd_pulse;
    logic         sel_shadow;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tf_window_bank #(
        .ADDR_W      (8),
        .DIRECT_BASE ('h80),
        .CH_STRIDE   ('h40)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid     (bus_valid),
        .bus_write     (bus_write),
        .bus_addr      (bus_addr),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .eng_error     (eng_error),
        .eng_status    (eng_status),
        .eng_tf        (eng_tf),
        .eng_data      (eng_data),
        .eng_cmd_pulse (eng_cmd_pulse),
        .sel_shadow    (sel_shadow)
    );

    // field index: 0 feat, 1 seccnt, 2 secnum, 3 cyllo, 4 cylhi, 5 devhead, 6 cmd
    function automatic logic [7:0] fld(input int ch, input int idx);
        return eng_tf[ch*56 + idx*8 +: 8];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
        #2 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 tf zero", {16'h0, eng_tf[111:64]}, 64'h0);
        check("R1 tf low zero", eng_tf[63:0], 64'h0);
        check("R1 data zero", eng_data, 64'h0);
        check("R1 shadow", sel_shadow, 0);
        check("R1 pulse", eng_cmd_pulse, 0);
        check("R1 rdata idle", bus_rdata, 0);
    endtask

    task automatic t_word0_lanes();
        logic [31:0] d;
        wr(8'h00, 4'b1110, 32'h4433_2211);
        check("R2 features", fld(0, 0), 8'h22);
        check("R2 seccnt", fld(0, 1), 8'h33);
        check("R2 secnum", fld(0, 2), 8'h44);
        check("R10 data byte kept", eng_data[31:0], 0);
        check("R4 ch1 untouched", fld(1, 0), 0);
        rd(8'h00, 4'b1110, d);
        check("R9 error read", d, 32'h4433_5A00);
    endtask

    task automatic t_word1_lanes();
        logic [31:0] d;
        wr(8'h04, 4'b1011, 32'h70AA_6261);
        check("R11 pulse ch0", eng_cmd_pulse, 2'b01);
        check("R3 cyllo", fld(0, 3), 8'h61);
        check("R3 cylhi", fld(0, 4), 8'h62);
        check("R3 cmd", fld(0, 6), 8'h70);
        check("R10 devhead kept", fld(0, 5), 0);
        check("R10 shadow kept", sel_shadow, 0);
        @(negedge clk);
        check("R11 pulse one cycle", eng_cmd_pulse, 0);
        rd(8'h04, 4'b1111, d);
        check("R9 status read", d, 32'h5000_6261);
    endtask

    task automatic t_shadow_steer();
        logic [31:0] d;
        wr(8'h04, 4'b0100, 32'h00F0_0000);
        check("R5 shadow set", sel_shadow, 1);
        check("R6 ch1 devhead bit4 clear", fld(1, 5), 8'hE0);
        check("R5 ch0 devhead untouched", fld(0, 5), 0);
        check("R11 no pulse", eng_cmd_pulse, 0);
        wr(8'h04, 4'b0001, 32'h0000_0099);
        check("R4 ch1 cyllo", fld(1, 3), 8'h99);
        check("R4 ch0 cyllo kept", fld(0, 3), 8'h61);
        rd(8'h04, 4'b1111, d);
        check("R4 read ch1", d, 32'h41E0_0099);
        wr(8'h04, 4'b0101, 32'h00A0_0077);
        check("R5 shadow cleared", sel_shadow, 0);
        check("R5 ch0 devhead", fld(0, 5), 8'hA0);
        check("R5 ch0 cyllo same access", fld(0, 3), 8'h77);
        check("R5 ch1 cyllo kept", fld(1, 3), 8'h99);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        wr(8'hC4, 4'b0001, 32'h0000_0011);
        check("R7 alias ch1 cyllo", fld(1, 3), 8'h11);
        check("R7 ch0 cyllo kept", fld(0, 3), 8'h77);
        wr(8'hC4, 4'b0100, 32'h001F_0000);
        check("R6 alias devhead", fld(1, 5), 8'h0F);
        check("R7 shadow unchanged", sel_shadow, 0);
        rd(8'hC4, 4'b1111, d);
        check("R7 alias read", d, 32'h410F_0011);
        rd(8'h04, 4'b1111, d);
        check("R7 shared still ch0", d, 32'h50A0_6277);
        wr(8'hC4, 4'b1000, 32'h3C00_0000);
        check("R11 pulse ch1", eng_cmd_pulse, 2'b10);
        check("R3 ch1 cmd", fld(1, 6), 8'h3C);
        wr(8'h80, 4'b0100, 32'h00AB_0000);
        check("R7 alias ch0 seccnt", fld(0, 1), 8'hAB);
    endtask

    task automatic t_data_widths();
        logic [31:0] d;
        wr(8'h00, 4'b1111, 32'hDEAD_BEEF);
        check("R8 dword write", eng_data[31:0], 32'hDEAD_BEEF);
        check("R8 secnum kept", fld(0, 2), 8'h44);
        check("R8 features kept", fld(0, 0), 8'h22);
        wr(8'h00, 4'b0011, 32'h0000_1234);
        check("R8 word write", eng_data[31:0], 32'hDEAD_1234);
        check("R8 features kept word", fld(0, 0), 8'h22);
        wr(8'h00, 4'b0001, 32'h0000_0056);
        check("R8 byte write", eng_data[31:0], 32'hDEAD_1256);
        rd(8'h00, 4'b1111, d);
        check("R8 dword read", d, 32'hDEAD_1256);
        rd(8'h00, 4'b0011, d);
        check("R8 word read", d, 32'h44AB_1256);
    endtask

    task automatic t_unmapped();
        logic [31:0]  d;
        logic [111:0] tf_snap;
        logic [63:0]  data_snap;
        int bad = 0;
        for (int a = 0; a < 256; a += 4) begin
            if (a != 'h00 && a != 'h04 && a != 'h80 && a != 'h84 && a != 'hC0 && a != 'hC4) begin
                rd(8'(a), 4'b1111, d);
                if (d != 0) bad++;
            end
        end
        check("R12 unmapped reads zero", bad, 0);
        rd(8'h05, 4'b1111, d);
        check("R12 misaligned read", d, 0);
        tf_snap = eng_tf; data_snap = eng_data;
        wr(8'h08, 4'b1111, 32'hFFFF_FFFF);
        wr(8'h06, 4'b1111, 32'hFFFF_FFFF);
        check("R12 tf unchanged", {16'h0, eng_tf[111:64]}, {16'h0, tf_snap[111:64]});
        check("R12 tf low unchanged", eng_tf[63:0], tf_snap[63:0]);
        check("R12 data unchanged", eng_data, data_snap);
        check("R12 shadow unchanged", sel_shadow, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word0_lanes();
        t_word1_lanes();
        t_shadow_steer();
        t_alias();
        t_data_widths();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule